// File: doc/BRIEF.md
# DMA Logical-to-Physical Address Translator

This block sits between the DMA channels and main memory and turns each 32-bit logical DMA address into a 29-bit physical address. The mapping is a page table kept in system memory. Each table slot is 8 bytes wide and its first 32-bit word carries the page frame. Software programs three settings through a small register port: where the table starts, how many bytes of it are valid, and a flush command. Any write to the flush command discards every cached translation.

A translation request is taken with a valid/ready handshake. The block checks the address range and the table bound first. It then looks the page up in a four-way fully associative cache tagged by logical page number. On a miss it reads the table word through a single-outstanding memory read port, installs the frame and answers. A request that falls outside the logical space or past the table bound gets an error response. The failing logical address is kept in a readable fault register.

Top module: `dma_addr_xlate`

## Requirements
- R1: A good response carries the physical address {frame word bits 28:12, logical address bits 11:0}. Frame word bits 31:29 and 11:0 play no part.
- R2: On a cache miss the block issues exactly one memory read, at table base + 8 × (logical bits 23:12). It issues no further read until that read's data has returned.
- R3: A logical address with any of bits 31:24 set gets an error response with a zero physical address, and no memory read is made for it.
- R4: A request whose table byte offset (8 × page index) is at or above the limit register gets an error response with no memory read. The limit resets to 0, so every request fails until it is programmed.
- R5: Each error stores the full 32-bit logical address in the fault register, read at select 3. The value stays until the next error. Writes to select 3 have no effect.
- R6: A request for a cached page is answered with no memory read, and rsp_valid rises on the first clock edge after the edge that took the request.
- R7: The cache holds four pages. A fill goes to the lowest-numbered empty slot. When every slot is full, the victim slot is picked round-robin: the pointer starts at slot 0 after reset and steps only on such fills.
- R8: A write of any value, including 0, to select 2 empties the whole cache on that write's clock edge. The next request for any page that was cached then reads memory again.
- R9: A flush that arrives while a table read is outstanding does not disturb that response. The fetched frame is returned but not installed, so the next request for that page reads memory again.
- R10: After reset, req_ready is 1 and rsp_valid and mem_req_valid are 0. req_ready is high only when no request is in progress. A response holds its value until rsp_ready, and a memory read request holds its address until mem_req_ready.
- R11: Select 0 (base) reads back the low 29 bits of the written value, with the upper bits reading 0. Select 1 (limit) reads back all 32 bits. Select 2 reads 0. Base, limit and fault all reset to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 base, 1 limit, 2 flush, 3 fault |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for cfg_sel (combinational) |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Translator can take a request |
| req_laddr | input | 32 | Logical address to translate |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_paddr | output | 29 | Physical address (0 on error) |
| rsp_err | output | 1 | Address error flag |
| mem_req_valid | output | 1 | Table read request valid |
| mem_req_ready | input | 1 | Memory takes the read request |
| mem_req_addr | output | 29 | Byte address of the table word |
| mem_rsp_valid | input | 1 | Table read data valid |
| mem_rsp_data | input | 32 | Table word holding the frame |

## Verification
A hit or an error response rises one edge after the accepting edge. A miss asks for its table word one edge later, and it answers on the edge after the edge where memory returns data. With one cycle of memory latency and no stalls, that is four edges after acceptance. A flush acts on the edge that takes its write. Register reads are combinational. The bench samples every output on the falling clock. It records the cycle in which each request was taken and the cycle in which its response first shows. It then compares the gap with the count above, except in phases where it stalls memory or the response on purpose. In those phases it checks that the held values stay stable. Memory reads are counted in the bench's own memory model, so every hit, miss and error is also checked for the exact number and address of table reads.

// File: rtl/xlate_pkg.sv
package xlate_pkg;

  // Walk sequencer states
  typedef enum logic [2:0] {
    W_IDLE  = 3'd0,
    W_CHECK = 3'd1,
    W_FETCH = 3'd2,
    W_WAIT  = 3'd3,
    W_RESP  = 3'd4
  } walk_st_e;

  // Register selects on the configuration port
  localparam logic [1:0] SEL_BASE  = 2'd0;
  localparam logic [1:0] SEL_LIMIT = 2'd1;
  localparam logic [1:0] SEL_FLUSH = 2'd2;
  localparam logic [1:0] SEL_FAULT = 2'd3;

endpackage

// File: rtl/xlate_cfg_regs.sv
module xlate_cfg_regs
  import xlate_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int PA_W   = 29
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        sel,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [PA_W-1:0]   tbl_base,
  output logic [DATA_W-1:0] tbl_limit,
  output logic              flush,
  input  logic              fault_we,
  input  logic [DATA_W-1:0] fault_addr
);

  logic [PA_W-1:0]   base_q,  base_d;
  logic [DATA_W-1:0] limit_q, limit_d;
  logic [DATA_W-1:0] fault_q, fault_d;
  logic              base_en, limit_en;

  assign base_en  = wr_en && (sel == SEL_BASE);
  assign limit_en = wr_en && (sel == SEL_LIMIT);
  assign flush    = wr_en && (sel == SEL_FLUSH);

  always_comb begin
    base_d  = base_en  ? wdata[PA_W-1:0] : base_q;
    limit_d = limit_en ? wdata           : limit_q;
    fault_d = fault_we ? fault_addr      : fault_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      limit_q <= '0;
      fault_q <= '0;
    end else begin
      base_q  <= base_d;
      limit_q <= limit_d;
      fault_q <= fault_d;
    end
  end

  always_comb begin
    unique case (sel)
      SEL_BASE:  rdata = DATA_W'(base_q);
      SEL_LIMIT: rdata = limit_q;
      SEL_FLUSH: rdata = '0;
      default:   rdata = fault_q;
    endcase
  end

  assign tbl_base  = base_q;
  assign tbl_limit = limit_q;

endmodule

// File: rtl/xlate_tag_cache.sv
module xlate_tag_cache #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 12,
  parameter int PFN_W = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic [TAG_W-1:0] lk_tag,
  output logic             hit,
  output logic [PFN_W-1:0] hit_pfn,
  input  logic             fill_en,
  input  logic [TAG_W-1:0] fill_tag,
  input  logic [PFN_W-1:0] fill_pfn
);

  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;
  localparam logic [WAY_W-1:0] LAST_WAY = WAY_W'(WAYS - 1);

  logic [WAYS-1:0]  vld_q, vld_d;
  logic [WAYS-1:0]  match;
  logic [WAYS-1:0]  wr_way;
  logic [TAG_W-1:0] tag_q [WAYS];
  logic [PFN_W-1:0] pfn_q [WAYS];
  logic [WAY_W-1:0] rr_q, rr_d;
  logic [WAY_W-1:0] free_idx, victim;
  logic             free_found;

  // Lowest-numbered empty slot
  always_comb begin
    free_found = 1'b0;
    free_idx   = '0;
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (!vld_q[i]) begin
        free_found = 1'b1;
        free_idx   = WAY_W'(i);
      end
    end
    victim = free_found ? free_idx : rr_q;
  end

  // Round-robin pointer steps only when a full cache takes a fill
  always_comb begin
    rr_d = rr_q;
    if (fill_en && !flush && !free_found) begin
      rr_d = (rr_q == LAST_WAY) ? '0 : rr_q + 1'b1;
    end
  end

  always_comb begin
    hit     = 1'b0;
    hit_pfn = '0;
    for (int i = 0; i < WAYS; i++) begin
      match[i]  = vld_q[i] && (tag_q[i] == lk_tag);
      wr_way[i] = fill_en && !flush && (victim == WAY_W'(i));
      vld_d[i]  = flush ? 1'b0 : (wr_way[i] | vld_q[i]);
      if (match[i]) begin
        hit     = 1'b1;
        hit_pfn = hit_pfn | pfn_q[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      rr_q  <= '0;
    end else begin
      vld_q <= vld_d;
      rr_q  <= rr_d;
    end
  end

  // Tag and frame storage, written only under the per-way enable
  for (genvar g = 0; g < WAYS; g++) begin : g_way
    always_ff @(posedge clk) begin
      if (wr_way[g]) begin
        tag_q[g] <= fill_tag;
        pfn_q[g] <= fill_pfn;
      end
    end
  end

endmodule

// File: rtl/xlate_walker.sv
module xlate_walker
  import xlate_pkg::*;
#(
  parameter int LA_W     = 32,
  parameter int LOG_BITS = 24,
  parameter int PG_BITS  = 12,
  parameter int PA_W     = 29,
  parameter int DATA_W   = 32,
  parameter int ENT_LOG  = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_valid,
  output logic                        req_ready,
  input  logic [LA_W-1:0]             req_laddr,
  output logic                        rsp_valid,
  input  logic                        rsp_ready,
  output logic [PA_W-1:0]             rsp_paddr,
  output logic                        rsp_err,
  output logic                        mem_req_valid,
  input  logic                        mem_req_ready,
  output logic [PA_W-1:0]             mem_req_addr,
  input  logic                        mem_rsp_valid,
  input  logic [DATA_W-1:0]           mem_rsp_data,
  input  logic [PA_W-1:0]             tbl_base,
  input  logic [DATA_W-1:0]           tbl_limit,
  input  logic                        flush,
  output logic                        fault_we,
  output logic [LA_W-1:0]             fault_addr,
  output logic [LOG_BITS-PG_BITS-1:0] lk_vpn,
  input  logic                        hit,
  input  logic [PA_W-PG_BITS-1:0]     hit_pfn,
  output logic                        fill_en,
  output logic [LOG_BITS-PG_BITS-1:0] fill_vpn,
  output logic [PA_W-PG_BITS-1:0]     fill_pfn
);

  localparam int VPN_W = LOG_BITS - PG_BITS;
  localparam int PFN_W = PA_W - PG_BITS;
  localparam int OFF_W = VPN_W + ENT_LOG;

  walk_st_e          st_q, st_d;
  logic [LA_W-1:0]   laddr_q, laddr_d;
  logic [PFN_W-1:0]  pfn_q, pfn_d;
  logic              err_q, err_d;
  logic              stale_q, stale_d;

  logic [VPN_W-1:0]  vpn;
  logic [OFF_W-1:0]  ent_off;
  logic              high_bad, lim_bad, addr_bad;

  assign vpn      = laddr_q[LOG_BITS-1:PG_BITS];
  assign ent_off  = {vpn, {ENT_LOG{1'b0}}};
  assign high_bad = |laddr_q[LA_W-1:LOG_BITS];
  assign lim_bad  = DATA_W'(ent_off) >= tbl_limit;
  assign addr_bad = high_bad || lim_bad;

  always_comb begin
    st_d    = st_q;
    laddr_d = laddr_q;
    pfn_d   = pfn_q;
    err_d   = err_q;
    stale_d = stale_q | flush;
    unique case (st_q)
      W_IDLE: begin
        if (req_valid) begin
          laddr_d = req_laddr;
          err_d   = 1'b0;
          stale_d = 1'b0;
          st_d    = W_CHECK;
        end
      end
      W_CHECK: begin
        if (addr_bad) begin
          err_d = 1'b1;
          st_d  = W_RESP;
        end else if (hit) begin
          pfn_d = hit_pfn;
          st_d  = W_RESP;
        end else begin
          st_d  = W_FETCH;
        end
      end
      W_FETCH: begin
        if (mem_req_ready) st_d = W_WAIT;
      end
      W_WAIT: begin
        if (mem_rsp_valid) begin
          pfn_d = mem_rsp_data[PA_W-1:PG_BITS];
          st_d  = W_RESP;
        end
      end
      W_RESP: begin
        if (rsp_ready) st_d = W_IDLE;
      end
      default: st_d = W_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= W_IDLE;
      laddr_q <= '0;
      pfn_q   <= '0;
      err_q   <= 1'b0;
      stale_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      laddr_q <= laddr_d;
      pfn_q   <= pfn_d;
      err_q   <= err_d;
      stale_q <= stale_d;
    end
  end

  assign req_ready     = (st_q == W_IDLE);
  assign rsp_valid     = (st_q == W_RESP);
  assign rsp_err       = err_q;
  assign rsp_paddr     = err_q ? '0 : {pfn_q, laddr_q[PG_BITS-1:0]};
  assign mem_req_valid = (st_q == W_FETCH);
  assign mem_req_addr  = tbl_base + PA_W'(ent_off);

  assign fault_we   = (st_q == W_CHECK) && addr_bad;
  assign fault_addr = laddr_q;

  assign lk_vpn   = vpn;
  assign fill_vpn = vpn;
  assign fill_pfn = mem_rsp_data[PA_W-1:PG_BITS];
  assign fill_en  = (st_q == W_WAIT) && mem_rsp_valid && !stale_q && !flush;

endmodule

// File: rtl/dma_addr_xlate.sv
module dma_addr_xlate #(
  parameter int LA_W     = 32,
  parameter int LOG_BITS = 24,
  parameter int PG_BITS  = 12,
  parameter int PA_W     = 29,
  parameter int DATA_W   = 32,
  parameter int ENT_LOG  = 3,
  parameter int WAYS     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_rdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [LA_W-1:0]   req_laddr,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [PA_W-1:0]   rsp_paddr,
  output logic              rsp_err,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [PA_W-1:0]   mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_data
);

  localparam int VPN_W = LOG_BITS - PG_BITS;
  localparam int PFN_W = PA_W - PG_BITS;

  // Reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_q_n = rst_sync_q[1];

  logic [PA_W-1:0]   tbl_base;
  logic [DATA_W-1:0] tbl_limit;
  logic              flush;
  logic              fault_we;
  logic [LA_W-1:0]   fault_addr;
  logic [VPN_W-1:0]  lk_vpn, fill_vpn;
  logic              hit, fill_en;
  logic [PFN_W-1:0]  hit_pfn, fill_pfn;

  xlate_cfg_regs #(
    .DATA_W (DATA_W),
    .PA_W   (PA_W)
  ) u_regs (
    .clk        (clk),
    .rst_n      (rst_q_n),
    .wr_en      (cfg_we),
    .sel        (cfg_sel),
    .wdata      (cfg_wdata),
    .rdata      (cfg_rdata),
    .tbl_base   (tbl_base),
    .tbl_limit  (tbl_limit),
    .flush      (flush),
    .fault_we   (fault_we),
    .fault_addr (DATA_W'(fault_addr))
  );

  xlate_tag_cache #(
    .WAYS  (WAYS),
    .TAG_W (VPN_W),
    .PFN_W (PFN_W)
  ) u_cache (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .flush    (flush),
    .lk_tag   (lk_vpn),
    .hit      (hit),
    .hit_pfn  (hit_pfn),
    .fill_en  (fill_en),
    .fill_tag (fill_vpn),
    .fill_pfn (fill_pfn)
  );

  xlate_walker #(
    .LA_W     (LA_W),
    .LOG_BITS (LOG_BITS),
    .PG_BITS  (PG_BITS),
    .PA_W     (PA_W),
    .DATA_W   (DATA_W),
    .ENT_LOG  (ENT_LOG)
  ) u_walk (
    .clk           (clk),
    .rst_n         (rst_q_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_laddr     (req_laddr),
    .rsp_valid     (rsp_valid),
    .rsp_ready     (rsp_ready),
    .rsp_paddr     (rsp_paddr),
    .rsp_err       (rsp_err),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data),
    .tbl_base      (tbl_base),
    .tbl_limit     (tbl_limit),
    .flush         (flush),
    .fault_we      (fault_we),
    .fault_addr    (fault_addr),
    .lk_vpn        (lk_vpn),
    .hit           (hit),
    .hit_pfn       (hit_pfn),
    .fill_en       (fill_en),
    .fill_vpn      (fill_vpn),
    .fill_pfn      (fill_pfn)
  );

endmodule

// File: rtl/xlate_checker.sv
module xlate_checker #(
  parameter int LA_W     = 32,
  parameter int LOG_BITS = 24,
  parameter int PG_BITS  = 12,
  parameter int PA_W     = 29,
  parameter int DATA_W   = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [LA_W-1:0]   req_laddr,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [PA_W-1:0]   rsp_paddr,
  input logic              rsp_err,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [PA_W-1:0]   mem_req_addr,
  input logic [1:0]        cfg_sel,
  input logic [DATA_W-1:0] cfg_rdata
);

  // Logical address of the request in progress, captured at the handshake
  logic [LA_W-1:0] cap_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       cap_q <= '0;
    else if (req_valid && req_ready)  cap_q <= req_laddr;
  end

  p_offset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_err |-> rsp_paddr[PG_BITS-1:0] == cap_q[PG_BITS-1:0]);

  p_one_fetch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !req_ready && !rsp_valid);

  p_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && (|cap_q[LA_W-1:LOG_BITS]) |-> rsp_err);

  p_err_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_err |-> rsp_paddr == '0);

  p_fault_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_err && cfg_sel == 2'd3 |-> cfg_rdata == DATA_W'(cap_q));

  p_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

  p_rsp_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_paddr) && $stable(rsp_err));

  p_mem_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

endmodule

bind dma_addr_xlate xlate_checker u_chk (
  .clk           (clk),
  .rst_n         (rst_q_n),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .req_laddr     (req_laddr),
  .rsp_valid     (rsp_valid),
  .rsp_ready     (rsp_ready),
  .rsp_paddr     (rsp_paddr),
  .rsp_err       (rsp_err),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_addr  (mem_req_addr),
  .cfg_sel       (cfg_sel),
  .cfg_rdata     (cfg_rdata)
);

// File: tb/sim_dma_addr_xlate.sv
module sim_dma_addr_xlate;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = 2'd0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_laddr = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [28:0] rsp_paddr;
  logic        rsp_err;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b1;
  logic [28:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;

  dma_addr_xlate u0 (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_laddr(req_laddr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr), .rsp_err(rsp_err),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
  );

  always #2.5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int fails  = 0;
  bit ended  = 0;

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", rq, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  // Table word model: frame bits 28:12 from a hash of the entry address
  function automatic logic [16:0] pfn_of(input logic [28:0] ea);
    logic [25:0] k;
    k = ea[28:3];
    return 17'(k * 26'd7 + 26'd3);
  endfunction

  function automatic logic [31:0] word_of(input logic [28:0] ea);
    return {3'b111, pfn_of(ea), 12'hABC};
  endfunction

  logic [28:0] base_v = '0;

  // ---------------- memory model ----------------
  int          mem_lat   = 1;
  bit          mem_stall = 0;
  int          mem_reads = 0;
  logic [28:0] mem_last  = '0;
  bit          pend = 0;
  int          pend_cnt = 0;
  logic [28:0] pend_addr = '0;
  bit          mprev_v = 0, mprev_r = 0;
  logic [28:0] mprev_a = '0;

  initial begin
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      if (pend) begin
        if (pend_cnt == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = word_of(pend_addr);
          pend = 0;
        end else pend_cnt--;
      end
      if (rst_n && mprev_v && !mprev_r)
        chk(mem_req_valid && mem_req_addr == mprev_a, "R10 mem hold", {35'd0, mem_req_addr}, {35'd0, mprev_a});
      mem_req_ready = mem_stall ? ~mem_req_ready : 1'b1;
      if (mem_req_valid && mem_req_ready) begin
        if (pend) chk(1'b0, "R2 second read while outstanding", 64'd1, 64'd0);
        pend      = 1;
        pend_cnt  = mem_lat;
        pend_addr = mem_req_addr;
        mem_reads++;
        mem_last  = mem_req_addr;
      end
      mprev_v = mem_req_valid;
      mprev_r = mem_req_ready;
      mprev_a = mem_req_addr;
    end
  end

  // ---------------- scoreboard monitor ----------------
  logic [28:0] q_pa[$];
  bit          q_err[$];
  string       q_rq[$];
  int          popped = 0;
  int          first_c = 0;
  bit          bp_mode = 0;
  int          held = 0;
  bit          prev_v = 0, prev_r = 0, prev_e = 0;
  logic [28:0] prev_pa = '0;

  initial begin
    forever begin
      @(negedge clk);
      if (rsp_valid) begin
        if (!prev_v) begin
          first_c = cyc;
          held = 0;
        end
        if (prev_v && !prev_r)
          chk(rsp_paddr == prev_pa && rsp_err == prev_e, "R10 rsp hold",
              {34'd0, rsp_err, rsp_paddr}, {34'd0, prev_e, prev_pa});
        rsp_ready = !bp_mode || (held >= 2);
        held++;
        if (rsp_ready) begin
          if (q_pa.size() == 0) begin
            chk(1'b0, "R10 unexpected response", {35'd0, rsp_paddr}, 64'd0);
          end else begin
            chk(rsp_err == q_err[0], {q_rq[0], " err"}, {63'd0, rsp_err}, {63'd0, q_err[0]});
            chk(rsp_paddr == q_pa[0], {q_rq[0], " paddr"}, {35'd0, rsp_paddr}, {35'd0, q_pa[0]});
            void'(q_pa.pop_front());
            void'(q_err.pop_front());
            void'(q_rq.pop_front());
          end
          popped++;
        end
      end else begin
        rsp_ready = 1'b0;
      end
      prev_v  = rsp_valid;
      prev_r  = rsp_ready;
      prev_pa = rsp_paddr;
      prev_e  = rsp_err;
    end
  end

  // ---------------- driver tasks ----------------
  task automatic cfg_write(input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cfg_read(input logic [1:0] s, output logic [31:0] d);
    @(negedge clk);
    cfg_sel = s;
    #1;
    d = cfg_rdata;
  endtask

  // exp_lat < 0 skips the latency check
  task automatic xact(input logic [31:0] la, input bit exp_err, input int exp_reads,
                      input int exp_lat, input string rq);
    logic [28:0] ea;
    logic [28:0] pa;
    int rd0, done0, acc_c;
    ea = base_v + {14'd0, la[23:12], 3'b000};
    pa = exp_err ? 29'd0 : {pfn_of(ea), la[11:0]};
    rd0 = mem_reads;
    done0 = popped;
    q_pa.push_back(pa);
    q_err.push_back(exp_err);
    q_rq.push_back(rq);
    @(negedge clk);
    req_valid = 1'b1;
    req_laddr = la;
    while (!req_ready) @(negedge clk);
    acc_c = cyc + 1;
    @(negedge clk);
    req_valid = 1'b0;
    while (popped != done0 + 1) @(negedge clk);
    chk(mem_reads - rd0 == exp_reads, {rq, " read count"}, 64'(mem_reads - rd0), 64'(exp_reads));
    if (exp_reads > 0)
      chk(mem_last == ea, {rq, " R2 table address"}, {35'd0, mem_last}, {35'd0, ea});
    if (exp_lat >= 0)
      chk(first_c - acc_c == exp_lat, {rq, " latency"}, 64'(first_c - acc_c), 64'(exp_lat));
  endtask

  function automatic logic [31:0] pg(input int p);
    return 32'(p) << 12;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // Reset state (R10, R11)
    chk(req_ready == 1'b1, "R10 reset req_ready", {63'd0, req_ready}, 64'd1);
    chk(rsp_valid == 1'b0, "R10 reset rsp_valid", {63'd0, rsp_valid}, 64'd0);
    chk(mem_req_valid == 1'b0, "R10 reset mem_req_valid", {63'd0, mem_req_valid}, 64'd0);
    cfg_read(2'd0, v); chk(v == 0, "R11 reset base", {32'd0, v}, 64'd0);
    cfg_read(2'd1, v); chk(v == 0, "R11 reset limit", {32'd0, v}, 64'd0);
    cfg_read(2'd3, v); chk(v == 0, "R11 reset fault", {32'd0, v}, 64'd0);

    // Limit 0 after reset: everything errors (R4, R5)
    xact(32'h0000_1234, 1, 0, 1, "R4 limit zero");
    cfg_read(2'd3, v); chk(v == 32'h0000_1234, "R5 fault after limit error", {32'd0, v}, 64'h1234);

    // Register readback (R11)
    cfg_write(2'd0, 32'hFFFF_F000);
    cfg_read(2'd0, v); chk(v == 32'h1FFF_F000, "R11 base width", {32'd0, v}, 64'h1FFF_F000);
    cfg_write(2'd0, 32'h0010_0000); base_v = 29'h0010_0000;
    cfg_write(2'd1, 32'h0000_8000);
    cfg_read(2'd1, v); chk(v == 32'h8000, "R11 limit readback", {32'd0, v}, 64'h8000);
    cfg_read(2'd2, v); chk(v == 0, "R11 flush reads zero", {32'd0, v}, 64'd0);

    // Miss then hit (R1, R2, R6)
    xact(32'h0000_0123, 0, 1, 4, "R1 R2 miss page 0");
    xact(32'h0000_0FFF, 0, 0, 1, "R6 hit page 0");
    xact(32'h00AB_C5A5, 0, 1, 4, "R1 miss page ABC");

    // Out of logical space (R3, R5)
    xact(32'h0100_0000, 1, 0, 1, "R3 bit 24 set");
    cfg_read(2'd3, v); chk(v == 32'h0100_0000, "R5 fault bit 24", {32'd0, v}, 64'h0100_0000);
    xact(32'hFFFF_FFFF, 1, 0, 1, "R3 all ones");
    cfg_read(2'd3, v); chk(v == 32'hFFFF_FFFF, "R5 fault all ones", {32'd0, v}, 64'hFFFF_FFFF);
    cfg_write(2'd3, 32'h0000_0055);
    cfg_read(2'd3, v); chk(v == 32'hFFFF_FFFF, "R5 fault write ignored", {32'd0, v}, 64'hFFFF_FFFF);

    // Limit boundary: 0x100 bytes covers pages 0..31 (R4)
    cfg_write(2'd1, 32'h0000_0100);
    xact(pg(32) | 32'h10, 1, 0, 1, "R4 first page past limit");
    xact(pg(31) | 32'h20, 0, 1, 4, "R4 last page inside limit");
    xact(pg(0)  | 32'h40, 0, 0, 1, "R4 cached page still inside");
    cfg_write(2'd1, 32'h0000_8000);

    // Replacement (R7): empty first, then round robin from slot 0
    cfg_write(2'd2, 32'h1234_5678);
    for (int p = 1; p <= 4; p++) xact(pg(p), 0, 1, 4, "R7 fill empty slot");
    xact(pg(5), 0, 1, 4, "R7 full cache fill");
    xact(pg(1), 0, 1, 4, "R7 slot 0 victim evicted");
    xact(pg(3), 0, 0, 1, "R7 page 3 kept");
    xact(pg(4), 0, 0, 1, "R7 page 4 kept");
    xact(pg(5), 0, 0, 1, "R7 page 5 kept");
    xact(pg(2), 0, 1, 4, "R7 slot 1 victim evicted");

    // Flush with value zero (R8)
    cfg_write(2'd2, 32'h0);
    xact(pg(3) | 32'h7, 0, 1, 4, "R8 refetch after flush");
    xact(pg(3) | 32'h8, 0, 0, 1, "R8 hit after refill");

    // Flush while a table read is outstanding (R9)
    mem_lat = 6;
    fork
      xact(pg(7) | 32'h321, 0, 1, 9, "R9 response during flush");
      begin
        repeat (4) @(negedge clk);
        cfg_write(2'd2, 32'h0);
      end
    join
    mem_lat = 1;
    xact(pg(7) | 32'h322, 0, 1, 4, "R9 page not installed");

    // Backpressure on memory and response (R10)
    bp_mode = 1;
    mem_stall = 1;
    mem_lat = 2;
    xact(pg(9) | 32'h9, 0, 1, -1, "R10 miss under stalls");
    xact(pg(9) | 32'hA, 0, 0, -1, "R10 hit under stalls");
    xact(32'h0200_0000, 1, 0, -1, "R10 error under stalls");
    xact(pg(10), 0, 1, -1, "R10 second miss under stalls");
    bp_mode = 0;
    mem_stall = 0;
    mem_lat = 1;
    repeat (4) @(negedge clk);
    chk(req_ready == 1'b1, "R10 idle after run", {63'd0, req_ready}, 64'd1);

    finish_run();
  end

endmodule